// File: doc/BRIEF.md
# DMA Stream Control Register

A control register for one DMA stream. Software reaches it over a simple synchronous register bus: a select, a write strobe, write data and read data. It holds the transfer direction, the flow-controller choice, circular mode, double-buffer mode, peripheral increment and peripheral data size, the four interrupt enables and the stream enable bit. Its fields drive a transfer engine, which keeps its own address counters.

The stored value is not always the value software wrote. While the stream is enabled, the fields that define the shape of the transfer are frozen. Hardware rules also adjust two fields. Memory-to-memory direction clears the peripheral flow-control bit. When the stream runs under peripheral flow control, circular mode is cleared. When the stream runs in double-buffer mode, circular mode is set.

The block also gives the per-item peripheral address step. It combines four status flags from the engine, each gated by its own enable, into one registered interrupt line. Every pin is a plain control or status signal. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dma_stream_ctrl`

## Requirements
- R1: After reset every field reads 0, `irq` is 0 and `per_step` is 0.
- R2: Readback and the `cfg_*` outputs show the stored fields at these bit positions: enable at 0, direct-mode-error enable at 1, transfer-error enable at 2, half-transfer enable at 3, transfer-complete enable at 4, peripheral flow control at 5, direction at 7:6, circular at 8, peripheral increment at 9, peripheral size at 12:11 and double-buffer at 18. All other bits read 0, and writing 1 to them has no effect.
- R3: A write made while the stored enable bit is 1 leaves direction, peripheral flow control, peripheral increment and peripheral size unchanged. The same write still updates enable, double-buffer, circular and the four interrupt enables. The lock uses the enable value from before the write.
- R4: Direction codes are 00 peripheral-to-memory, 01 memory-to-peripheral and 10 memory-to-memory. A write of direction 11 keeps the previous direction. A write of peripheral size 11 keeps the previous size.
- R5: While the direction is 10, peripheral flow control reads 0, even when 1 was written.
- R6: While enable is 1 and peripheral flow control is 1, circular reads 0. This rule takes priority over R7.
- R7: While enable is 1, double-buffer is 1 and peripheral flow control is 0, circular reads 1. This holds from the same clock edge at which enable is stored as 1.
- R8: `per_step` is 0 when peripheral increment is 0. Otherwise it gives the step in bytes: 1, 2 or 4 for peripheral size 00, 01 or 10.
- R9: `irq` is registered. One cycle after the inputs, it is the OR of each `evt_flags` bit ANDed with its enable. Bit 0 is direct-mode error, bit 1 transfer error, bit 2 half transfer and bit 3 transfer complete.
- R10: `rd_data` is 0 while `reg_sel` is 0, and a write strobe without `reg_sel` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Write strobe, used only when selected |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, 0 when not selected |
| evt_flags | input | 4 | Status flags {complete, half, error, direct-mode error} |
| cfg_en | output | 1 | Stream enable |
| cfg_dir | output | 2 | Effective transfer direction |
| cfg_pfctrl | output | 1 | Effective peripheral flow control |
| cfg_circ | output | 1 | Effective circular mode |
| cfg_dbm | output | 1 | Double-buffer mode |
| cfg_psize | output | 2 | Peripheral data size code |
| per_step | output | 3 | Peripheral address step in bytes |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest state to reach is a write that arrives while the stream is enabled and also clears the enable bit. That write must still be refused for the locked fields, because the lock uses the enable value from before the write. A second, identical write must then be accepted. The stimulus enables the stream with peripheral flow control and double-buffer both set, so that the R6 priority over R7 is visible. It then writes conflicting values while the stream is enabled, then writes all zeros twice and reads back after each write. A scoreboard queue holds the expected readback of each step, computed from the field rules.

// File: rtl/dma_scfg_pkg.sv
package dma_scfg_pkg;

  localparam int POS_EN    = 0;
  localparam int POS_DMEIE = 1;
  localparam int POS_TEIE  = 2;
  localparam int POS_HTIE  = 3;
  localparam int POS_TCIE  = 4;
  localparam int POS_PFC   = 5;
  localparam int POS_DIR   = 6;
  localparam int POS_CIRC  = 8;
  localparam int POS_PINC  = 9;
  localparam int POS_PSZ   = 11;
  localparam int POS_DBM   = 18;
  localparam int IMG_W     = POS_DBM + 1;
  localparam int N_EVT     = 4;

  typedef enum logic [1:0] {
    XD_P2M  = 2'b00,
    XD_M2P  = 2'b01,
    XD_M2M  = 2'b10,
    XD_RSVD = 2'b11
  } xfer_dir_e;

  typedef struct packed {
    logic             en;
    logic             dbm;
    logic [1:0]       psize;
    logic             pinc;
    logic             circ;
    xfer_dir_e        dir;
    logic             pfctrl;
    logic [N_EVT-1:0] irq_en;   // [3] complete, [2] half, [1] error, [0] direct-mode error
  } scfg_t;

  function automatic logic [IMG_W-1:0] scfg_image(input scfg_t c);
    logic [IMG_W-1:0] v;
    v                            = '0;
    v[POS_EN]                    = c.en;
    v[POS_DMEIE +: N_EVT]        = c.irq_en;
    v[POS_PFC]                   = c.pfctrl;
    v[POS_DIR +: 2]              = c.dir;
    v[POS_CIRC]                  = c.circ;
    v[POS_PINC]                  = c.pinc;
    v[POS_PSZ +: 2]              = c.psize;
    v[POS_DBM]                   = c.dbm;
    return v;
  endfunction

endpackage

// File: rtl/scfg_fields.sv
module scfg_fields
  import dma_scfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output scfg_t             cfg
);

  scfg_t cfg_q;
  scfg_t cand;
  logic  locked;

  assign locked = cfg_q.en;

  always_comb begin
    cand = cfg_q;
    if (wr_en) begin
      cand.en     = wr_data[POS_EN];
      cand.dbm    = wr_data[POS_DBM];
      cand.circ   = wr_data[POS_CIRC];
      cand.irq_en = wr_data[POS_DMEIE +: N_EVT];
      if (!locked) begin
        cand.pinc   = wr_data[POS_PINC];
        cand.pfctrl = wr_data[POS_PFC];
        if (wr_data[POS_DIR +: 2] != XD_RSVD)
          cand.dir = xfer_dir_e'(wr_data[POS_DIR +: 2]);
        if (wr_data[POS_PSZ +: 2] != 2'b11)
          cand.psize = wr_data[POS_PSZ +: 2];
      end
    end
    // hardware overrides on the next-state value
    if (cand.dir == XD_M2M)
      cand.pfctrl = 1'b0;
    if (cand.en && cand.pfctrl)
      cand.circ = 1'b0;
    else if (cand.en && cand.dbm)
      cand.circ = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cand;
  end

  assign cfg = cfg_q;

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && wr_en) |=> ($stable(cfg_q.dir) && $stable(cfg_q.pinc) &&
                             $stable(cfg_q.psize) && $stable(cfg_q.pfctrl))); // R3
  AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.dir != XD_RSVD); // R4
  AST_PSZ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.psize != 2'b11); // R4
  AST_M2M_NO_PFC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.dir == XD_M2M) |-> !cfg_q.pfctrl); // R5
  AST_PFC_KILLS_CIRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.pfctrl) |-> !cfg_q.circ); // R6
  AST_DBM_SETS_CIRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.en && cfg_q.dbm && !cfg_q.pfctrl) |-> cfg_q.circ); // R7

endmodule

// File: rtl/scfg_step.sv
module scfg_step #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pinc,
  input  logic [1:0]        psize,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  always_comb begin
    if (pinc) step = ONE << psize;
    else      step = '0;
  end

  AST_STEP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !pinc |-> (step == '0)); // R8
  AST_STEP_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    pinc |-> ($countones(step) == 1)); // R8

endmodule

// File: rtl/scfg_irq.sv
module scfg_irq #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] enables,
  output logic             irq
);

  logic [N_SRC-1:0] masked;
  logic             irq_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_mask
    assign masked[i] = flags[i] & enables[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |masked;
  end

  assign irq = irq_q;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & enables)) |=> irq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & enables)) |=> !irq); // R9

endmodule

// File: rtl/dma_stream_ctrl.sv
module dma_stream_ctrl
  import dma_scfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_EVT-1:0]  evt_flags,
  output logic              cfg_en,
  output logic [1:0]        cfg_dir,
  output logic              cfg_pfctrl,
  output logic              cfg_circ,
  output logic              cfg_dbm,
  output logic [1:0]        cfg_psize,
  output logic [STEP_W-1:0] per_step,
  output logic              irq
);

  scfg_t            cfg;
  logic             wr_hit;
  logic [IMG_W-1:0] image;

  assign wr_hit = reg_sel & reg_we;

  scfg_fields #(.DATA_W(DATA_W)) u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hit),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  scfg_step #(.STEP_W(STEP_W)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .pinc  (cfg.pinc),
    .psize (cfg.psize),
    .step  (per_step)
  );

  scfg_irq #(.N_SRC(N_EVT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (evt_flags),
    .enables (cfg.irq_en),
    .irq     (irq)
  );

  assign image   = scfg_image(cfg);
  assign rd_data = reg_sel ? DATA_W'(image) : '0;

  assign cfg_en     = cfg.en;
  assign cfg_dir    = cfg.dir;
  assign cfg_pfctrl = cfg.pfctrl;
  assign cfg_circ   = cfg.circ;
  assign cfg_dbm    = cfg.dbm;
  assign cfg_psize  = cfg.psize;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (!cfg_en && !irq && per_step == '0)); // R1

endmodule

// File: tb/tb_dma_stream_ctrl.sv
module tb_dma_stream_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  evt_flags = '0;
  logic        cfg_en, cfg_pfctrl, cfg_circ, cfg_dbm;
  logic [1:0]  cfg_dir, cfg_psize;
  logic [2:0]  per_step;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  logic rd_req = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int cyc = 0;

  always #2 clk = ~clk;

  dma_stream_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .wr_data(wr_data), .rd_data(rd_data), .evt_flags(evt_flags),
    .cfg_en(cfg_en), .cfg_dir(cfg_dir), .cfg_pfctrl(cfg_pfctrl),
    .cfg_circ(cfg_circ), .cfg_dbm(cfg_dbm), .cfg_psize(cfg_psize),
    .per_step(per_step), .irq(irq)
  );

  function automatic logic [31:0] img(input logic en, dme, te, ht, tc, pfc,
                                      input logic [1:0] dir, input logic circ,
                                      pinc, input logic [1:0] ps, input logic dbm);
    return {13'b0, dbm, 5'b0, ps, 1'b0, pinc, circ, dir, pfc, tc, ht, te, dme, en};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected readback for each read cycle
  always @(negedge clk) begin
    if (rd_req && exp_q.size() > 0) begin
      chk(rd_data, exp_q.pop_front(), tag_q.pop_front());
      chk({28'b0, cfg_en, cfg_circ, cfg_pfctrl, cfg_dbm},
          {28'b0, rd_data[0], rd_data[8], rd_data[5], rd_data[18]}, "R2 outputs");
      chk({30'b0, cfg_dir}, {30'b0, rd_data[7:6]}, "R2 dir out");
    end
  end

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1;
    reg_sel = 1'b1; reg_we = 1'b1; wr_data = d;
    @(posedge clk); #1;
    reg_sel = 1'b0; reg_we = 1'b0; wr_data = '0;
  endtask

  task automatic rd_expect(input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_sel = 1'b1; reg_we = 1'b0; rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({31'b0, irq}, 32'd0, "R1 irq");
    chk({29'b0, per_step}, 32'd0, "R1 step");
    rd_expect(32'd0, "R1 reset image");

    wr(img(0,1,1,1,1,1,2'b01,1,1,2'b01,0));
    rd_expect(img(0,1,1,1,1,1,2'b01,1,1,2'b01,0), "R2 plain write");
    @(negedge clk); chk({29'b0, per_step}, 32'd2, "R8 step size 01");

    wr(img(0,1,1,1,1,1,2'b10,1,1,2'b01,0));
    rd_expect(img(0,1,1,1,1,0,2'b10,1,1,2'b01,0), "R5 m2m clears pfctrl");

    wr(img(0,1,1,1,1,0,2'b11,1,1,2'b11,0));
    rd_expect(img(0,1,1,1,1,0,2'b10,1,1,2'b01,0), "R4 reserved dir/size kept");

    wr(img(1,0,0,0,0,1,2'b00,0,1,2'b10,1));
    rd_expect(img(1,0,0,0,0,1,2'b00,0,1,2'b10,1), "R6 pfctrl beats dbm");
    @(negedge clk); chk({29'b0, per_step}, 32'd4, "R8 step size 10");

    wr(img(1,0,0,0,1,0,2'b01,1,0,2'b00,1));
    rd_expect(img(1,0,0,0,1,1,2'b00,0,1,2'b10,1), "R3 locked while enabled");

    wr(32'd0);
    rd_expect(img(0,0,0,0,0,1,2'b00,0,1,2'b10,0), "R3 disabling write still locked");
    wr(32'd0);
    rd_expect(32'd0, "R3 unlocked write");
    @(negedge clk); chk({29'b0, per_step}, 32'd0, "R8 no increment");

    wr(img(1,0,0,0,0,0,2'b01,0,0,2'b00,1));
    rd_expect(img(1,0,0,0,0,0,2'b01,1,0,2'b00,1), "R7 dbm forces circ");

    wr(32'hFFFF_FFFF);
    rd_expect(img(1,1,1,1,1,0,2'b01,1,0,2'b00,1), "R2 reserved bits");

    @(posedge clk); #1;
    reg_sel = 1'b0; reg_we = 1'b1; wr_data = 32'd0;
    @(negedge clk); chk(rd_data, 32'd0, "R10 rd_data idle");
    @(posedge clk); #1; reg_we = 1'b0;
    rd_expect(img(1,1,1,1,1,0,2'b01,1,0,2'b00,1), "R10 unselected write ignored");

    @(posedge clk); #1; evt_flags = 4'b0010;
    @(negedge clk); chk({31'b0, irq}, 32'd0, "R9 latency");
    @(posedge clk); #1; evt_flags = 4'b0000;
    @(negedge clk); chk({31'b0, irq}, 32'd1, "R9 raise");
    @(negedge clk); chk({31'b0, irq}, 32'd0, "R9 fall");

    wr(img(0,0,1,0,0,0,2'b00,0,0,2'b00,0));
    @(posedge clk); #1; evt_flags = 4'b1101;
    @(negedge clk); @(negedge clk);
    chk({31'b0, irq}, 32'd0, "R9 masked flags");
    @(posedge clk); #1; evt_flags = 4'b0010;
    @(negedge clk); @(negedge clk);
    chk({31'b0, irq}, 32'd1, "R9 enabled flag");
    evt_flags = 4'b0000;
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule